// File: doc/BRIEF.md
# Paper-Tape Binary Image Parser

This block parses the byte stream of a punched-tape binary image and turns it into memory write requests. Frames arrive one per cycle over a valid/ready handshake. The block skips the leader and deletion marks. It pairs 6-bit frames into words and sorts those words into origin settings and data. Each data word is written to the address made of a 3-bit memory field and a 12-bit origin, and the origin then advances.

Frames with the top bit set change the field. The new field waits in a holding register and takes effect once the current word is complete. When a word pair is followed by the end mark, that pair is read as a checksum. It is compared against the running sum of every earlier frame pair.

The write port carries no handshake: a write is a single-cycle pulse. Once the end mark is seen the block stops accepting frames until it is reset. The result is then reported on three flags: finished, checksum mismatch, and address beyond the configured memory.

Top module: `tape_image_loader`

## Requirements
- R1: After a synchronous reset, `done`, `checksum_error`, `overflow` and `wr_en` are 0, `in_ready` is 1, and the field and origin are 0.
- R2: A frame of 0377 is discarded, and the next accepted frame is discarded too, whatever its value (including 0377 or 0200).
- R3: Any other frame above 0200 sets a pending field from its bits 5:3. The pending field becomes the write field when the next word pair completes. The frame itself takes no part in word assembly.
- R4: While in leader, frames of 0 and 0200 are skipped. The first other frame becomes the high half of the first word.
- R5: A word is (high << 6) | low. A pair completes when the next word frame arrives and is not 0200. A completed data word appears as `wr_en`=1, with `wr_addr` = {field, origin} and `wr_data` = word[11:0], in the cycle after the clock edge that accepted that next frame.
- R6: A completed word with bit 12 set loads the origin from its low 12 bits and causes no write.
- R7: After every data word the origin increments modulo 4096 (07777 wraps to 0).
- R8: A 0200 frame that follows a complete pair ends the load. `done` becomes 1 one cycle later, `in_ready` falls, and later frames cause no writes and change no flags.
- R9: The checksum is the sum of the high and low frames of every pair before the final one. `checksum_error` is set with `done` when that sum and the final word differ in their low 12 bits.
- R10: A data word whose {field, origin} address is at or above `MEM_WORDS` is not written. It sets `overflow`, which stays set until reset, and the origin still increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Frame present |
| in_frame | input | 8 | Tape frame |
| in_ready | output | 1 | Frame accepted when high together with in_valid |
| wr_en | output | 1 | Single-cycle write strobe |
| wr_addr | output | 15 | Write address, {field, origin} |
| wr_data | output | 12 | Write data |
| done | output | 1 | End mark reached |
| checksum_error | output | 1 | Checksum mismatch at end |
| overflow | output | 1 | A write fell beyond memory size |

## Verification
The hardest case to reach is a frame that would normally end the load or start a word but arrives right after a deletion mark. The stimulus table places 0377 followed by 0200 between two data pairs. If that 0200 were not swallowed, the load would end early and the following writes would go missing. A field frame placed between the two halves of a pair shows that the field change waits until that pair completes. A directed run starts at origin 07777 with a small memory size. It covers the origin wrap and, in the same stream, a field that points past the end of memory.

// File: rtl/tl_pkg.sv
package tl_pkg;

  localparam int FRAME_W  = 8;
  localparam int FIELD_W  = 3;
  localparam int ORIGIN_W = 12;
  localparam int WORD_W   = ORIGIN_W + 1;
  localparam int HALF_W   = 6;
  localparam int ADDR_W   = FIELD_W + ORIGIN_W;

  localparam logic [FRAME_W-1:0] FR_RUBOUT = 8'o377;
  localparam logic [FRAME_W-1:0] FR_MARK   = 8'o200;

  typedef enum logic [1:0] {
    ST_LEADER = 2'd0,
    ST_LOW    = 2'd1,
    ST_PAIR   = 2'd2,
    ST_DONE   = 2'd3
  } asm_state_t;

  function automatic logic [WORD_W-1:0] join_pair(input logic [6:0] hi,
                                                  input logic [7:0] lo);
    logic [WORD_W-1:0] h;
    h = {hi, {HALF_W{1'b0}}};
    return h | {{(WORD_W-8){1'b0}}, lo};
  endfunction

  function automatic logic [8:0] pair_sum(input logic [6:0] hi,
                                          input logic [7:0] lo);
    return {2'b00, hi} + {1'b0, lo};
  endfunction

endpackage

// File: rtl/tl_frame_filter.sv
module tl_frame_filter
  import tl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic [FRAME_W-1:0]  frame,
  output logic                data_evt,
  output logic                field_evt,
  output logic [FIELD_W-1:0]  field_val
);

  logic skip_q;
  logic is_rubout;
  logic is_field;

  assign is_rubout = (frame == FR_RUBOUT);
  assign is_field  = frame[7] && (frame[6:0] != 7'd0) && !is_rubout;

  assign data_evt  = accept && !skip_q && !is_rubout && !is_field;
  assign field_evt = accept && !skip_q && is_field;
  assign field_val = frame[5:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q <= 1'b0;
    end else if (accept) begin
      if (skip_q) skip_q <= 1'b0;
      else        skip_q <= is_rubout;
    end
  end

  // R2: the frame after a deletion mark yields no event
  a_r2_skip_follower: assert property (@(posedge clk) disable iff (rst)
    (accept && is_rubout && !skip_q) |=> !(data_evt || field_evt));

endmodule

// File: rtl/tl_word_builder.sv
module tl_word_builder
  import tl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                data_evt,
  input  logic [FRAME_W-1:0]  frame,
  output logic                word_evt,
  output logic                end_evt,
  output logic [WORD_W-1:0]   word,
  output logic [6:0]          hi_half,
  output logic [7:0]          lo_half,
  output logic                finished
);

  asm_state_t state_q;
  logic [6:0] hi_q;
  logic [7:0] lo_q;
  logic       is_mark;
  logic       is_leader;

  assign is_mark   = (frame == FR_MARK);
  assign is_leader = is_mark || (frame == '0);

  assign word     = join_pair(hi_q, lo_q);
  assign hi_half  = hi_q;
  assign lo_half  = lo_q;
  assign word_evt = data_evt && (state_q == ST_PAIR) && !is_mark;
  assign end_evt  = data_evt && (state_q == ST_PAIR) && is_mark;
  assign finished = (state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LEADER;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (data_evt) begin
      case (state_q)
        ST_LEADER: begin
          if (!is_leader) begin
            hi_q    <= frame[6:0];
            state_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          lo_q    <= frame;
          state_q <= ST_PAIR;
        end
        ST_PAIR: begin
          if (is_mark) begin
            state_q <= ST_DONE;
          end else begin
            hi_q    <= frame[6:0];
            state_q <= ST_LOW;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  // R8: once finished, the parser stays finished
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    finished |=> finished);

  // R4: leader frames never leave the leader state
  a_r4_leader_skip: assert property (@(posedge clk) disable iff (rst)
    (data_evt && state_q == ST_LEADER && is_leader) |=> (state_q == ST_LEADER));

endmodule

// File: rtl/tl_address_gen.sv
module tl_address_gen
  import tl_pkg::*;
#(
  parameter int MEM_WORDS = 32768
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                word_evt,
  input  logic [WORD_W-1:0]   word,
  input  logic                field_evt,
  input  logic [FIELD_W-1:0]  field_val,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [ORIGIN_W-1:0] wr_data,
  output logic                overflow
);

  localparam logic [ADDR_W:0] MEM_LIMIT = MEM_WORDS[ADDR_W:0];

  logic [FIELD_W-1:0]  field_q;
  logic [FIELD_W-1:0]  pend_q;
  logic [ORIGIN_W-1:0] origin_q;
  logic [ADDR_W-1:0]   target;
  logic                in_range;
  logic                is_origin;
  logic                wr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [ORIGIN_W-1:0] data_q;
  logic                ovf_q;

  function automatic logic fits(input logic [ADDR_W-1:0] a);
    return ({1'b0, a} < MEM_LIMIT);
  endfunction

  assign target    = {field_q, origin_q};
  assign in_range  = fits(target);
  assign is_origin = word[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q  <= '0;
      pend_q   <= '0;
      origin_q <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (field_evt) pend_q <= field_val;
      if (word_evt) begin
        field_q <= pend_q;
        if (is_origin) begin
          origin_q <= word[ORIGIN_W-1:0];
        end else begin
          origin_q <= origin_q + 1'b1;
          if (in_range) begin
            wr_q   <= 1'b1;
            addr_q <= target;
            data_q <= word[ORIGIN_W-1:0];
          end else begin
            ovf_q <= 1'b1;
          end
        end
      end
    end
  end

  assign wr_en    = wr_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign overflow = ovf_q;

  // R7: each data word advances the origin by one, wrapping at 4096
  a_r7_origin_step: assert property (@(posedge clk) disable iff (rst)
    (word_evt && !is_origin) |=> (origin_q == $past(origin_q) + 1'b1));

  // R10: no write leaves the configured memory
  a_r10_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_addr} < MEM_LIMIT));

  // R10: overflow is sticky
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R6: origin words never produce a write
  a_r6_origin_no_write: assert property (@(posedge clk) disable iff (rst)
    (word_evt && is_origin) |=> !wr_en);

endmodule

// File: rtl/tl_checksum.sv
module tl_checksum
  import tl_pkg::*;
#(
  parameter int SUM_W = 14
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_evt,
  input  logic              end_evt,
  input  logic [6:0]        hi_half,
  input  logic [7:0]        lo_half,
  input  logic [WORD_W-1:0] word,
  output logic              mismatch
);

  logic [SUM_W-1:0] acc_q;
  logic             err_q;

  function automatic logic differs(input logic [SUM_W-1:0] acc,
                                   input logic [WORD_W-1:0] w);
    logic [SUM_W-1:0] diff;
    diff = acc - SUM_W'(w);
    return (diff[ORIGIN_W-1:0] != '0);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      err_q <= 1'b0;
    end else if (word_evt) begin
      acc_q <= acc_q + SUM_W'(pair_sum(hi_half, lo_half));
    end else if (end_evt) begin
      err_q <= differs(acc_q, word);
    end
  end

  assign mismatch = err_q;

  // R9: the error flag changes only at the end mark
  a_r9_err_at_end: assert property (@(posedge clk) disable iff (rst)
    (!end_evt) |=> $stable(mismatch));

endmodule

// File: rtl/tape_image_loader.sv
module tape_image_loader
  import tl_pkg::*;
#(
  parameter int MEM_WORDS = 32768,
  parameter int SUM_W     = 14
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_frame,
  output logic        in_ready,
  output logic        wr_en,
  output logic [14:0] wr_addr,
  output logic [11:0] wr_data,
  output logic        done,
  output logic        checksum_error,
  output logic        overflow
);

  logic                accept;
  logic                data_evt;
  logic                field_evt;
  logic [FIELD_W-1:0]  field_val;
  logic                word_evt;
  logic                end_evt;
  logic [WORD_W-1:0]   word;
  logic [6:0]          hi_half;
  logic [7:0]          lo_half;
  logic                finished;

  assign in_ready = !finished;
  assign accept   = in_valid && in_ready;
  assign done     = finished;

  tl_frame_filter u_filter (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .frame     (in_frame),
    .data_evt  (data_evt),
    .field_evt (field_evt),
    .field_val (field_val)
  );

  tl_word_builder u_builder (
    .clk      (clk),
    .rst      (rst),
    .data_evt (data_evt),
    .frame    (in_frame),
    .word_evt (word_evt),
    .end_evt  (end_evt),
    .word     (word),
    .hi_half  (hi_half),
    .lo_half  (lo_half),
    .finished (finished)
  );

  tl_address_gen #(.MEM_WORDS(MEM_WORDS)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .word_evt  (word_evt),
    .word      (word),
    .field_evt (field_evt),
    .field_val (field_val),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .overflow  (overflow)
  );

  tl_checksum #(.SUM_W(SUM_W)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .word_evt (word_evt),
    .end_evt  (end_evt),
    .hi_half  (hi_half),
    .lo_half  (lo_half),
    .word     (word),
    .mismatch (checksum_error)
  );

  // R8: nothing is written after the load has ended
  a_r8_no_write_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !wr_en);

  // R9: a checksum error is only reported together with done
  a_r9_err_needs_done: assert property (@(posedge clk) disable iff (rst)
    checksum_error |-> done);

endmodule

// File: tb/sim_tape_image_loader.sv
module sim_tape_image_loader;

  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 8192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_frame = '0;
  logic        in_ready;
  logic        wr_en;
  logic [14:0] wr_addr;
  logic [11:0] wr_data;
  logic        done;
  logic        checksum_error;
  logic        overflow;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  tape_image_loader #(.MEM_WORDS(MEMW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_frame(in_frame),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .checksum_error(checksum_error), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {frame, expected write, expected address, expected data}
  localparam int NV = 18;
  localparam logic [35:0] VEC [NV] = '{
    {8'o200, 1'b0, 15'o0,     12'o0},
    {8'o200, 1'b0, 15'o0,     12'o0},
    {8'o102, 1'b0, 15'o0,     12'o0},
    {8'o000, 1'b0, 15'o0,     12'o0},
    {8'o012, 1'b0, 15'o0,     12'o0},
    {8'o034, 1'b0, 15'o0,     12'o0},
    {8'o377, 1'b0, 15'o0,     12'o0},
    {8'o200, 1'b0, 15'o0,     12'o0},
    {8'o076, 1'b1, 15'o00200, 12'o1234},
    {8'o054, 1'b0, 15'o0,     12'o0},
    {8'o310, 1'b0, 15'o0,     12'o0},
    {8'o000, 1'b1, 15'o00201, 12'o7654},
    {8'o017, 1'b0, 15'o0,     12'o0},
    {8'o000, 1'b1, 15'o10202, 12'o0017},
    {8'o001, 1'b0, 15'o0,     12'o0},
    {8'o003, 1'b1, 15'o10203, 12'o0001},
    {8'o042, 1'b0, 15'o0,     12'o0},
    {8'o200, 1'b0, 15'o0,     12'o0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] f);
    in_valid = 1'b1;
    in_frame = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 checksum_error", checksum_error, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 in_ready", in_ready, 1);

    // Main table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][35:28]);
      chk("R5 wr_en", wr_en, VEC[i][27]);
      if (VEC[i][27]) begin
        chk("R5 R3 wr_addr", wr_addr, VEC[i][26:12]);
        chk("R5 wr_data", wr_data, VEC[i][11:0]);
      end
    end
    chk("R8 done", done, 1);
    chk("R8 in_ready", in_ready, 0);
    chk("R9 good checksum", checksum_error, 0);
    // R8: frames after the end are ignored
    send(8'o012);
    send(8'o034);
    send(8'o000);
    chk("R8 no write after end", wr_en, 0);
    chk("R8 done held", done, 1);
    chk("R8 flags held", {checksum_error, overflow}, 0);

    // R9 bad checksum, with R2 double rubout at the start
    do_reset();
    send(8'o377); send(8'o377);
    send(8'o101); send(8'o000);
    send(8'o000); send(8'o005);
    send(8'o000);
    chk("R2 R6 write after double rubout", wr_en, 1);
    chk("R2 R6 origin address", wr_addr, 15'o00100);
    chk("R5 data", wr_data, 12'o0005);
    send(8'o007); send(8'o200);
    chk("R9 done", done, 1);
    chk("R9 mismatch", checksum_error, 1);

    // R7 wrap and R10 overflow
    do_reset();
    send(8'o177); send(8'o077);
    send(8'o000); send(8'o011);
    send(8'o000);
    chk("R7 last origin write", wr_addr, 15'o07777);
    chk("R5 data 011", wr_data, 12'o0011);
    send(8'o022); send(8'o330);
    send(8'o000);
    chk("R7 wrap wr_en", wr_en, 1);
    chk("R7 wrap addr", wr_addr, 15'o00000);
    chk("R3 field pending, not yet applied", overflow, 0);
    send(8'o033); send(8'o000);
    chk("R10 write suppressed", wr_en, 0);
    chk("R10 overflow", overflow, 1);
    send(8'o000); send(8'o200);
    chk("R10 overflow held", overflow, 1);
    chk("R8 done after overflow", done, 1);

    summary();
  end

endmodule